// File: doc/BRIEF.md
# Control IN Endpoint Register and Handshake Selector

This block keeps the control/status word for the default control endpoint in the IN direction of a USB device controller. Software reads and writes the word through a simple 32-bit register port with a write strobe. The controller core feeds it events: a SETUP packet arrived, the current transfer finished, and a pending disable has been carried out. The block updates the endpoint's enable, disable, NAK and stall state from these events and from software writes. When both touch the same bit in the same cycle, the hardware event wins.

For every token, a combinational arbiter picks the handshake the endpoint gives. It uses the endpoint state, the two global NAK requests, whether the transmit FIFO holds data, and whether the current token is a SETUP data packet. The block also decodes the max-packet-size code into a byte count. It raises single-cycle interrupt pulses for "endpoint disabled" and "transfer complete". Each pulse comes only after the enable bit already reads 0. A strap input selects shared or dedicated transmit FIFO operation, and this affects the FIFO-number field.

Top module: `ep0_in_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x0000_8000. Bit 15 always reads 1, bits 19:18 (endpoint kind, 00 = control) always read 00, and every reserved bit reads 0.
- R2: Writing 1 to bit 27 sets the NAK status bit (bit 17), and writing 1 to bit 26 clears it. Bits 27 and 26 always read 0. If both are 1 in one write, the NAK status becomes 1.
- R3: A SETUP event sets NAK status and clears the stall bit. It overrides a software write in the same cycle for both bits.
- R4: The stall bit (bit 21) is set by writing 1. Writing 0 leaves it unchanged.
- R5: The handshake code hs_o is 0 = DATA, 1 = NAK, 2 = STALL, 3 = ACK, chosen by fixed priority. A SETUP data token gets ACK. Otherwise a set stall bit gives STALL. Otherwise the answer is NAK if NAK status, either global NAK, a cleared enable bit or an empty FIFO is present. Otherwise the answer is DATA.
- R6: The enable bit (bit 31) is set by writing 1. Writing 0 leaves it unchanged. Hardware clears it.
- R7: A write of 1 to the disable bit (bit 30) takes effect only while the enable bit is 1. Otherwise the bit stays 0.
- R8: A disable acknowledge while the disable bit is set clears bits 31 and 30 at the next edge. irq_ep_off then pulses high for exactly one cycle, starting one edge later.
- R9: A transfer-complete event while enabled clears bit 31 at the next edge. irq_xfer_done then pulses high for exactly one cycle, starting one edge later.
- R10: Bits 1:0 hold the max-packet code. pkt_bytes gives 64, 32, 16 or 8 bytes for codes 00, 01, 10 and 11.
- R11: With fifo_dedicated = 1, bits 25:22 store and read back the written FIFO number. With fifo_dedicated = 0, writes to these bits are ignored and the field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| ev_setup | input | 1 | SETUP packet received on this endpoint |
| ev_xfer_done | input | 1 | Core finished the current transfer |
| ev_off_ack | input | 1 | Core has carried out the requested disable |
| tok_setup | input | 1 | Current token is a SETUP data packet |
| gnp_in_nak | input | 1 | Global non-periodic IN NAK active |
| g_out_nak | input | 1 | Global OUT NAK active |
| fifo_has_data | input | 1 | Transmit FIFO holds data for this endpoint |
| fifo_dedicated | input | 1 | Strap: 1 = dedicated FIFOs, 0 = shared FIFO |
| hs_o | output | 2 | Handshake choice: 0 DATA, 1 NAK, 2 STALL, 3 ACK |
| pkt_bytes | output | 7 | Decoded max packet size in bytes |
| irq_ep_off | output | 1 | Endpoint-disabled interrupt pulse |
| irq_xfer_done | output | 1 | Transfer-complete interrupt pulse |

## Verification
The assertions check on every cycle the rules that follow from state alone. SETUP forces NAK and drops stall, stall is sticky, ACK and STALL win the arbitration, and DATA never goes out while a NAK source is present. Each interrupt pulse follows a cycle in which enable was already 0, and the decoded packet size is always a single power of two. The bench scenarios cover what only sequences can show. These include the exact reset value, read-back of the write-only bits as 0, set-only behaviour against a write of 0, and a disable request while disabled being dropped. They also cover same-cycle conflicts between a SETUP and a write, the exact cycle and width of each interrupt pulse, and the FIFO-number field following the strap.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

   typedef enum logic [1:0] {
      HS_DATA  = 2'd0,
      HS_NAK   = 2'd1,
      HS_STALL = 2'd2,
      HS_ACK   = 2'd3
   } hs_e;

   localparam int REG_W     = 32;
   localparam int B_ON      = 31;
   localparam int B_OFF     = 30;
   localparam int B_NSET    = 27;
   localparam int B_NCLR    = 26;
   localparam int B_FIFO_LO = 22;
   localparam int FIFO_SLOT = 4;
   localparam int B_HALT    = 21;
   localparam int B_KIND_LO = 18;
   localparam int B_NAKST   = 17;
   localparam int B_LIVE    = 15;

endpackage

// File: rtl/ep0_nak_stall.sv
module ep0_nak_stall (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_nset,
   input  logic wr_nclr,
   input  logic wr_halt,
   input  logic ev_setup,
   output logic nak_o,
   output logic halt_o
);

   logic nak_q, halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nak_q  <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         if (ev_setup)                nak_q <= 1'b1;
         else if (wr_en && wr_nset)   nak_q <= 1'b1;
         else if (wr_en && wr_nclr)   nak_q <= 1'b0;

         if (ev_setup)                halt_q <= 1'b0;
         else if (wr_en && wr_halt)   halt_q <= 1'b1;
      end
   end

   assign nak_o  = nak_q;
   assign halt_o = halt_q;

   assert_setup_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_setup |=> (nak_q && !halt_q));

   assert_halt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !ev_setup) |=> halt_q);

   assert_nak_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_nset) |=> nak_q);

endmodule

// File: rtl/ep0_enable_ctl.sv
module ep0_enable_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_on,
   input  logic wr_off,
   input  logic ev_done,
   input  logic ev_off_ack,
   output logic on_o,
   output logic off_o,
   output logic irq_off_o,
   output logic irq_done_o
);

   logic on_q, off_q;
   logic pend_off, pend_done;
   logic irq_off_q, irq_done_q;
   logic done_hit, off_hit;

   assign done_hit = ev_done && on_q;
   assign off_hit  = ev_off_ack && off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q       <= 1'b0;
         off_q      <= 1'b0;
         pend_off   <= 1'b0;
         pend_done  <= 1'b0;
         irq_off_q  <= 1'b0;
         irq_done_q <= 1'b0;
      end else begin
         if (done_hit || off_hit)      on_q <= 1'b0;
         else if (wr_en && wr_on)      on_q <= 1'b1;

         if (off_hit)                  off_q <= 1'b0;
         else if (wr_en && wr_off && on_q) off_q <= 1'b1;

         pend_off   <= off_hit;
         pend_done  <= done_hit;
         irq_off_q  <= pend_off;
         irq_done_q <= pend_done;
      end
   end

   assign on_o       = on_q;
   assign off_o      = off_q;
   assign irq_off_o  = irq_off_q;
   assign irq_done_o = irq_done_q;

   assert_off_needs_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off && !on_q && !off_q) |=> !off_q);

   assert_irq_off_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_off_q |-> !$past(on_q));

   assert_irq_off_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_off_q |=> !irq_off_q);

   assert_irq_done_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done_q |-> !$past(on_q));

   assert_irq_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done_q |=> !irq_done_q);

endmodule

// File: rtl/ep0_hs_arb.sv
module ep0_hs_arb
   import ep0_pkg::*;
#(
   parameter int NAK_SRCS = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tok_setup,
   input  logic                halt,
   input  logic [NAK_SRCS-1:0] nak_srcs,
   output hs_e                 hs
);

   if (NAK_SRCS < 1) begin : g_bad_srcs
      $error("NAK_SRCS must be at least 1");
   end

   logic any_nak;
   assign any_nak = |nak_srcs;

   always_comb begin
      if (tok_setup)    hs = HS_ACK;
      else if (halt)    hs = HS_STALL;
      else if (any_nak) hs = HS_NAK;
      else              hs = HS_DATA;
   end

   assert_setup_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tok_setup |-> (hs == HS_ACK));

   assert_stall_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !tok_setup) |-> (hs == HS_STALL));

   assert_no_data_on_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hs == HS_DATA) |-> (nak_srcs == '0 && !halt));

endmodule

// File: rtl/ep0_pkt_dec.sv
module ep0_pkt_dec #(
   parameter int CODE_W     = 2,
   parameter int BASE_BYTES = 64,
   parameter int BYTES_W    = 7,
   parameter bit USE_SHIFT  = 1'b1
) (
   input  logic [CODE_W-1:0]  code,
   output logic [BYTES_W-1:0] bytes
);

   localparam int NCODES = 1 << CODE_W;

   if ((BASE_BYTES >> (NCODES - 1)) == 0) begin : g_bad_base
      $error("BASE_BYTES too small for CODE_W");
   end

   if (USE_SHIFT) begin : g_shift
      localparam logic [BYTES_W-1:0] BASE_V = BYTES_W'(BASE_BYTES);
      assign bytes = BASE_V >> code;
   end else begin : g_table
      always_comb begin
         bytes = '0;
         for (int i = 0; i < NCODES; i++) begin
            if (code == CODE_W'(i)) bytes = BYTES_W'(BASE_BYTES >> i);
         end
      end
   end

endmodule

// File: rtl/ep0_in_ctrl_reg.sv
module ep0_in_ctrl_reg
   import ep0_pkg::*;
#(
   parameter int FIFO_NUM_W       = 4,
   parameter int PKT_CODE_W       = 2,
   parameter int BASE_PKT_BYTES   = 64,
   parameter int PKT_BYTES_W      = 7,
   parameter bit PKT_DECODE_SHIFT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   csr_we,
   input  logic [31:0]            csr_wdata,
   output logic [31:0]            csr_rdata,
   input  logic                   ev_setup,
   input  logic                   ev_xfer_done,
   input  logic                   ev_off_ack,
   input  logic                   tok_setup,
   input  logic                   gnp_in_nak,
   input  logic                   g_out_nak,
   input  logic                   fifo_has_data,
   input  logic                   fifo_dedicated,
   output logic [1:0]             hs_o,
   output logic [PKT_BYTES_W-1:0] pkt_bytes,
   output logic                   irq_ep_off,
   output logic                   irq_xfer_done
);

   localparam int NEED_BYTES_W = $clog2(BASE_PKT_BYTES) + 1;

   if (FIFO_NUM_W < 1 || FIFO_NUM_W > FIFO_SLOT) begin : g_bad_fifo
      $error("FIFO_NUM_W must be 1..4");
   end
   if (PKT_CODE_W != 2) begin : g_bad_code
      $error("PKT_CODE_W must be 2");
   end
   if (PKT_BYTES_W != NEED_BYTES_W) begin : g_bad_bytes
      $error("PKT_BYTES_W does not match BASE_PKT_BYTES");
   end

   logic                  on, off, nak, halt;
   logic [FIFO_NUM_W-1:0] fifo_q;
   logic [PKT_CODE_W-1:0] pkt_q;
   hs_e                   hs;

   ep0_nak_stall u_nak (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (csr_we),
      .wr_nset  (csr_wdata[B_NSET]),
      .wr_nclr  (csr_wdata[B_NCLR]),
      .wr_halt  (csr_wdata[B_HALT]),
      .ev_setup (ev_setup),
      .nak_o    (nak),
      .halt_o   (halt)
   );

   ep0_enable_ctl u_en (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (csr_we),
      .wr_on      (csr_wdata[B_ON]),
      .wr_off     (csr_wdata[B_OFF]),
      .ev_done    (ev_xfer_done),
      .ev_off_ack (ev_off_ack),
      .on_o       (on),
      .off_o      (off),
      .irq_off_o  (irq_ep_off),
      .irq_done_o (irq_xfer_done)
   );

   ep0_hs_arb #(.NAK_SRCS(5)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tok_setup (tok_setup),
      .halt      (halt),
      .nak_srcs  ({nak, gnp_in_nak, g_out_nak, !on, !fifo_has_data}),
      .hs        (hs)
   );

   assign hs_o = hs;

   ep0_pkt_dec #(
      .CODE_W     (PKT_CODE_W),
      .BASE_BYTES (BASE_PKT_BYTES),
      .BYTES_W    (PKT_BYTES_W),
      .USE_SHIFT  (PKT_DECODE_SHIFT)
   ) u_dec (
      .code  (pkt_q),
      .bytes (pkt_bytes)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_q <= '0;
         pkt_q  <= '0;
      end else if (csr_we) begin
         pkt_q <= csr_wdata[PKT_CODE_W-1:0];
         if (fifo_dedicated) fifo_q <= csr_wdata[B_FIFO_LO +: FIFO_NUM_W];
      end
   end

   always_comb begin
      csr_rdata             = '0;
      csr_rdata[B_ON]       = on;
      csr_rdata[B_OFF]      = off;
      csr_rdata[B_HALT]     = halt;
      csr_rdata[B_KIND_LO +: 2] = 2'b00;
      csr_rdata[B_NAKST]    = nak;
      csr_rdata[B_LIVE]     = 1'b1;
      csr_rdata[PKT_CODE_W-1:0] = pkt_q;
      if (fifo_dedicated) csr_rdata[B_FIFO_LO +: FIFO_NUM_W] = fifo_q;
   end

   logic wdata_unused;
   assign wdata_unused = ^{csr_wdata[29:28], csr_wdata[20:15], csr_wdata[14:PKT_CODE_W],
                           csr_wdata[B_FIFO_LO + FIFO_SLOT - 1 : B_FIFO_LO]};

   assert_pkt_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pkt_bytes) == 1);

   assert_fifo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_we && fifo_dedicated) |=> $stable(fifo_q));

endmodule

// File: tb/ep0_in_ctrl_reg_tb.sv
module ep0_in_ctrl_reg_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        ev_setup = 1'b0, ev_xfer_done = 1'b0, ev_off_ack = 1'b0;
   logic        tok_setup = 1'b0, gnp_in_nak = 1'b0, g_out_nak = 1'b0;
   logic        fifo_has_data = 1'b0, fifo_dedicated = 1'b0;
   logic [1:0]  hs_o;
   logic [6:0]  pkt_bytes;
   logic        irq_ep_off, irq_xfer_done;

   int vec = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ep0_in_ctrl_reg u_dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .ev_setup(ev_setup), .ev_xfer_done(ev_xfer_done),
      .ev_off_ack(ev_off_ack), .tok_setup(tok_setup), .gnp_in_nak(gnp_in_nak),
      .g_out_nak(g_out_nak), .fifo_has_data(fifo_has_data),
      .fifo_dedicated(fifo_dedicated), .hs_o(hs_o), .pkt_bytes(pkt_bytes),
      .irq_ep_off(irq_ep_off), .irq_xfer_done(irq_xfer_done)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [31:0] d);
      csr_we = 1'b1;
      csr_wdata = d;
      step();
      csr_we = 1'b0;
      csr_wdata = '0;
   endtask

   task automatic t_reset();
      check("R1 reset value", csr_rdata, 32'h0000_8000);
      check("R5 disabled gives NAK", {30'd0, hs_o}, 32'd1);
      check("R10 reset size", {25'd0, pkt_bytes}, 32'd64);
      check("R9 no irq at reset", {30'd0, irq_ep_off, irq_xfer_done}, 32'd0);
   endtask

   task automatic t_nak_bits();
      wr(32'h0800_0000);
      check("R2 set-NAK", csr_rdata, 32'h0002_8000);
      wr(32'h0400_0000);
      check("R2 clear-NAK", csr_rdata, 32'h0000_8000);
      wr(32'h0C00_0000);
      check("R2 both set wins", csr_rdata, 32'h0002_8000);
      wr(32'h0400_0000);
      check("R1 reserved zero", csr_rdata, 32'h0000_8000);
   endtask

   task automatic t_stall_sticky();
      wr(32'h0020_0000);
      check("R4 stall set", csr_rdata, 32'h0020_8000);
      wr(32'h0000_0000);
      check("R4 stall write 0 ignored", csr_rdata, 32'h0020_8000);
   endtask

   task automatic t_priority();
      wr(32'h8800_0000);
      check("R6 enable set", csr_rdata, 32'h8022_8000);
      gnp_in_nak = 1'b1; fifo_has_data = 1'b1; #1;
      check("R5 stall beats NAK", {30'd0, hs_o}, 32'd2);
      tok_setup = 1'b1; #1;
      check("R5 setup ACK", {30'd0, hs_o}, 32'd3);
      tok_setup = 1'b0;
      ev_setup = 1'b1; step(); ev_setup = 1'b0;
      check("R3 setup event", csr_rdata, 32'h8002_8000);
      check("R5 NAK status", {30'd0, hs_o}, 32'd1);
      tok_setup = 1'b1; #1;
      check("R5 ACK despite NAK", {30'd0, hs_o}, 32'd3);
      tok_setup = 1'b0; gnp_in_nak = 1'b0;
      wr(32'h0400_0000);
      check("R5 data", {30'd0, hs_o}, 32'd0);
      gnp_in_nak = 1'b1; #1;
      check("R5 global IN NAK", {30'd0, hs_o}, 32'd1);
      gnp_in_nak = 1'b0; g_out_nak = 1'b1; #1;
      check("R5 global OUT NAK", {30'd0, hs_o}, 32'd1);
      g_out_nak = 1'b0; fifo_has_data = 1'b0; #1;
      check("R5 empty FIFO", {30'd0, hs_o}, 32'd1);
      fifo_has_data = 1'b1; #1;
      check("R5 data again", {30'd0, hs_o}, 32'd0);
   endtask

   task automatic t_setup_vs_write();
      ev_setup = 1'b1;
      wr(32'h0420_0000);
      ev_setup = 1'b0;
      check("R3 setup beats write", csr_rdata, 32'h8002_8000);
      wr(32'h0400_0000);
      wr(32'h0000_0000);
      check("R6 enable write 0 ignored", csr_rdata, 32'h8000_8000);
   endtask

   task automatic t_done();
      ev_xfer_done = 1'b1; step(); ev_xfer_done = 1'b0;
      check("R9 enable cleared", csr_rdata, 32'h0000_8000);
      check("R9 irq not yet", {31'd0, irq_xfer_done}, 32'd0);
      step();
      check("R9 irq pulse", {31'd0, irq_xfer_done}, 32'd1);
      step();
      check("R9 irq one cycle", {31'd0, irq_xfer_done}, 32'd0);
   endtask

   task automatic t_disable();
      wr(32'h4000_0000);
      check("R7 disable ignored", csr_rdata, 32'h0000_8000);
      wr(32'h8000_0000);
      wr(32'h4000_0000);
      check("R7 disable accepted", csr_rdata, 32'hC000_8000);
      ev_off_ack = 1'b1; step(); ev_off_ack = 1'b0;
      check("R8 bits cleared", csr_rdata, 32'h0000_8000);
      check("R8 irq not yet", {31'd0, irq_ep_off}, 32'd0);
      step();
      check("R8 irq pulse", {30'd0, irq_ep_off, irq_xfer_done}, 32'd2);
      step();
      check("R8 irq one cycle", {31'd0, irq_ep_off}, 32'd0);
   endtask

   task automatic t_pkt();
      for (int c = 0; c < 4; c++) begin
         wr(32'(c));
         check("R10 size", {25'd0, pkt_bytes}, 32'(64 >> c));
         check("R10 code readback", {30'd0, csr_rdata[1:0]}, 32'(c));
      end
      wr(32'h0);
   endtask

   task automatic t_fifo();
      fifo_dedicated = 1'b0;
      wr(32'h0140_0000);
      check("R11 shared ignores", csr_rdata, 32'h0000_8000);
      fifo_dedicated = 1'b1; #1;
      check("R11 shared write not stored", {28'd0, csr_rdata[25:22]}, 32'd0);
      wr(32'h0140_0000);
      check("R11 dedicated stores", {28'd0, csr_rdata[25:22]}, 32'd5);
      fifo_dedicated = 1'b0; #1;
      check("R11 shared reads 0", {28'd0, csr_rdata[25:22]}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      step();
      step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_nak_bits();
      t_stall_sticky();
      t_priority();
      t_setup_vs_write();
      t_done();
      t_disable();
      t_pkt();
      t_fifo();
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule